// File: doc/BRIEF.md
# EPROM Programming-Mode Interface Controller

This block is the slave-side control logic that places an on-chip EPROM into a program or verify mode and steers its address and data paths. After reset, a 10-bit mode code is shifted in on a serial line, one bit per system clock with the least significant bit first. The complete code is then matched against two fixed patterns, one for program mode and one for verify mode. Any other value leaves the block idle.

The 11-bit array address shares one 8-bit port. While the address-select input is high, the port carries the upper part. The falling edge of address-select captures that part, provided select was held high long enough. With select low, the port carries the low byte, which counts as settled only after a fixed number of quiet cycles. In program mode, a train of pulses on the program strobe commits the input data byte to the addressed location. In verify mode, the block drives the stored byte out and raises an output enable. A behavioural memory stands in for the EPROM cells. The data port is split into an input, an output and an enable, so the pad ring can form the bidirectional pin. All pins are plain level signals with no handshake: the interface applies no back-pressure, and the external programmer owns all timing.

Top module: `eprom_prog_ctrl`

## Requirements
- R1: Starting with the first rising edge after reset release, `code_in` is sampled on 10 consecutive edges and assembled least significant bit first. Code 10'h2A5 selects program mode (`prog_active`=1). Code 10'h15A selects verify mode (`verify_active`=1). Any other code leaves both low. Both stay low until the 10th bit has been taken.
- R2: Once the code is complete, further activity on `code_in` has no effect on the mode until the next reset.
- R3: A falling edge of `asel` captures `addr_port[7:5]` as address bits 10:8 only if `asel` was high on at least 13 consecutive rising edges. A shorter high phase marks the upper part as not accepted, and `addr_valid` stays low until a correct high phase follows.
- R4: The captured upper part never changes while `asel` is high; it changes only at an accepted falling edge.
- R5: With `asel` low, `addr_port` forms address bits 7:0. `addr_valid` rises 13 edges after the first edge that samples a new low byte, so it is 0 after 13 edges and 1 after 14. Any change of the port value drops `addr_valid` on the next edge and restarts the wait.
- R6: `addr_valid` is low whenever `asel` is high or no upper part has been accepted since reset.
- R7: In program mode with `addr_valid` high, the 25th rising edge counted on `pgm_strobe` writes `data_in` to the current address. `write_done` is high for exactly the following cycle. Further pulses write nothing until `addr_valid` falls. A drop of `addr_valid` discards a partial pulse count.
- R8: `data_oe` is high only in verify mode with `addr_valid` high. In that state, `data_out` carries the stored byte at the current address; otherwise `data_out` is 0.
- R9: In verify mode, `pgm_strobe` and `data_in` have no effect on the array contents.
- R10: Array contents survive `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; restarts code reception |
| code_in | input | 1 | Serial mode code, LSB first |
| asel | input | 1 | Address select: high = upper part on port |
| addr_port | input | 8 | Shared address port |
| pgm_strobe | input | 1 | Program strobe, counted on rising edges |
| data_in | input | 8 | Byte to program |
| data_out | output | 8 | Byte read in verify mode |
| data_oe | output | 1 | Output enable for the data pad |
| prog_active | output | 1 | Program mode selected |
| verify_active | output | 1 | Verify mode selected |
| addr_valid | output | 1 | Address captured and settled |
| write_done | output | 1 | One-cycle pulse after a committed write |

## Verification
Mode decoding is tried with five codes: the two legal ones, all zeros, a program code with its lowest bit flipped, and the program code sent most significant bit first. The last two are only rejected if the bit order and every bit position really matter. Address handling is driven with high phases of 12 and 13 edges to locate the acceptance boundary, with low bytes sampled exactly at the 13th and 14th settle edges, and with a low-byte change in the middle of a pulse train. Two locations that share a low byte but differ in the upper part are written and read back after a reset, which separates the upper address bits and shows that storage is retained. Pulse trains of 24, 25 and 26 pulses, plus a full train in verify mode, separate counting from commit and from suppression.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_PROG   = 2'd1,
    MODE_VERIFY = 2'd2
  } pmode_e;

  localparam int CODE_W          = 10;
  localparam logic [CODE_W-1:0] CODE_PROG   = 10'h2A5;
  localparam logic [CODE_W-1:0] CODE_VERIFY = 10'h15A;
endpackage

// File: rtl/eprom_code_rx.sv
module eprom_code_rx
  import eprom_prog_pkg::*;
#(
  parameter int                W        = CODE_W,
  parameter logic [W-1:0]      PROG_PAT = CODE_PROG,
  parameter logic [W-1:0]      VER_PAT  = CODE_VERIFY
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   code_in,
  output pmode_e mode,
  output logic   code_done
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] NBITS = CW'(W);

  logic [W-1:0]  shreg;
  logic [CW-1:0] nbits;

  // LSB arrives first, so new bits enter at the top and move down
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      nbits <= '0;
    end else if (nbits != NBITS) begin
      shreg <= {code_in, shreg[W-1:1]};
      nbits <= nbits + 1'b1;
    end
  end

  assign code_done = (nbits == NBITS);

  always_comb begin
    mode = MODE_IDLE;
    if (code_done) begin
      if (shreg == PROG_PAT)     mode = MODE_PROG;
      else if (shreg == VER_PAT) mode = MODE_VERIFY;
    end
  end

  // R2: the decided mode is frozen until reset
  assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    code_done |=> $stable(mode));
endmodule

// File: rtl/eprom_addr_demux.sv
module eprom_addr_demux #(
  parameter int ADDR_W = 11,
  parameter int PORT_W = 8,
  parameter int HI_MIN = 13,
  parameter int SETTLE = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              asel,
  input  logic [PORT_W-1:0] addr_port,
  output logic [ADDR_W-1:0] addr,
  output logic              addr_valid
);
  localparam int HI_BITS = ADDR_W - PORT_W;
  localparam int HCW     = $clog2(HI_MIN + 1);
  localparam int SCW     = $clog2(SETTLE + 1);
  localparam logic [HCW-1:0] HI_LIM = HCW'(HI_MIN);
  localparam logic [SCW-1:0] ST_LIM = SCW'(SETTLE);

  logic               asel_d;
  logic [HCW-1:0]     hi_cnt;
  logic [HI_BITS-1:0] hi_q;
  logic               hi_ok;
  logic [PORT_W-1:0]  lo_q;
  logic [SCW-1:0]     st_cnt;
  logic               asel_fall;

  assign asel_fall = asel_d && !asel;

  // upper part: length of the high phase decides acceptance at the fall
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asel_d <= 1'b0;
      hi_cnt <= '0;
      hi_q   <= '0;
      hi_ok  <= 1'b0;
    end else begin
      asel_d <= asel;
      if (asel) begin
        if (hi_cnt != HI_LIM) hi_cnt <= hi_cnt + 1'b1;
      end else begin
        hi_cnt <= '0;
      end
      if (asel_fall) begin
        if (hi_cnt == HI_LIM) begin
          hi_q  <= addr_port[PORT_W-1 -: HI_BITS];
          hi_ok <= 1'b1;
        end else begin
          hi_ok <= 1'b0;
        end
      end
    end
  end

  // low byte: any change restarts the settle count
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q   <= '0;
      st_cnt <= '0;
    end else if (asel || (addr_port != lo_q)) begin
      lo_q   <= addr_port;
      st_cnt <= '0;
    end else if (st_cnt != ST_LIM) begin
      st_cnt <= st_cnt + 1'b1;
    end
  end

  assign addr       = {hi_q, lo_q};
  assign addr_valid = hi_ok && !asel && (st_cnt == ST_LIM);

  // R4: upper part is held while select is high
  assert_hi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    asel |=> $stable(hi_q));
  // R3: a short high phase withdraws acceptance
  assert_short_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (asel_fall && hi_cnt != HI_LIM) |=> !addr_valid);
  // R5: a new port value drops validity on the next edge
  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!asel && addr_port != lo_q) |=> !addr_valid);
endmodule

// File: rtl/eprom_pulse_ctr.sv
module eprom_pulse_ctr #(
  parameter int PULSES = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic strobe,
  output logic commit,
  output logic done_pulse
);
  localparam int PCW = $clog2(PULSES + 1);
  localparam logic [PCW-1:0] P_ALL  = PCW'(PULSES);
  localparam logic [PCW-1:0] P_LAST = PCW'(PULSES - 1);

  logic           strobe_d;
  logic [PCW-1:0] cnt;
  logic           rise;

  assign rise   = strobe && !strobe_d;
  assign commit = enable && rise && (cnt == P_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_d   <= 1'b0;
      cnt        <= '0;
      done_pulse <= 1'b0;
    end else begin
      strobe_d   <= strobe;
      done_pulse <= commit;
      if (!enable)                 cnt <= '0;
      else if (rise && cnt != P_ALL) cnt <= cnt + 1'b1;
    end
  end

  // R7: one commit per valid window
  assert_single_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
  // R7: done pulse lasts one cycle
  assert_done_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);
endmodule

// File: rtl/eprom_array.sv
module eprom_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/eprom_prog_ctrl.sv
module eprom_prog_ctrl
  import eprom_prog_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PORT_W = 8,
  parameter int DATA_W = 8,
  parameter int HI_MIN = 13,
  parameter int SETTLE = 13,
  parameter int PULSES = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_in,
  input  logic              asel,
  input  logic [PORT_W-1:0] addr_port,
  input  logic              pgm_strobe,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              prog_active,
  output logic              verify_active,
  output logic              addr_valid,
  output logic              write_done
);
  pmode_e            mode;
  logic              code_done;
  logic [ADDR_W-1:0] addr;
  logic              commit;
  logic [DATA_W-1:0] rdata;

  eprom_code_rx #(.W(CODE_W), .PROG_PAT(CODE_PROG), .VER_PAT(CODE_VERIFY)) u_code (
    .clk(clk), .rst_n(rst_n), .code_in(code_in),
    .mode(mode), .code_done(code_done)
  );

  eprom_addr_demux #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .HI_MIN(HI_MIN), .SETTLE(SETTLE)) u_addr (
    .clk(clk), .rst_n(rst_n), .asel(asel), .addr_port(addr_port),
    .addr(addr), .addr_valid(addr_valid)
  );

  eprom_pulse_ctr #(.PULSES(PULSES)) u_pulse (
    .clk(clk), .rst_n(rst_n),
    .enable(prog_active && addr_valid),
    .strobe(pgm_strobe),
    .commit(commit), .done_pulse(write_done)
  );

  eprom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .we(commit), .addr(addr), .wdata(data_in), .rdata(rdata)
  );

  assign prog_active   = (mode == MODE_PROG);
  assign verify_active = (mode == MODE_VERIFY);
  assign data_oe       = verify_active && addr_valid;
  assign data_out      = data_oe ? rdata : '0;

  // R8: pad driven only in verify mode, never before the code is complete
  assert_oe_verify_R8: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (code_done && !prog_active));
  // R9: no write pulse can appear in verify mode
  assert_no_write_verify_R9: assert property (@(posedge clk) disable iff (!rst_n)
    verify_active |=> !write_done);
endmodule

// File: tb/test_eprom_prog_ctrl.sv
module test_eprom_prog_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       code_in = 1'b0;
  logic       asel = 1'b0;
  logic [7:0] addr_port = 8'h00;
  logic       pgm_strobe = 1'b0;
  logic [7:0] data_in = 8'h00;
  logic [7:0] data_out;
  logic       data_oe, prog_active, verify_active, addr_valid, write_done;

  int n_cmp = 0;
  int n_bad = 0;
  int done_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eprom_prog_ctrl i_eprom_prog_ctrl (
    .clk(clk), .rst_n(rst_n), .code_in(code_in), .asel(asel),
    .addr_port(addr_port), .pgm_strobe(pgm_strobe), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .prog_active(prog_active),
    .verify_active(verify_active), .addr_valid(addr_valid), .write_done(write_done)
  );

  always @(posedge clk) if (write_done === 1'b1) done_seen++;

  // {code[9:0], expect_prog, expect_verify}
  localparam logic [11:0] VEC [0:4] = '{
    {10'h2A5, 1'b1, 1'b0},
    {10'h15A, 1'b0, 1'b1},
    {10'h000, 1'b0, 1'b0},
    {10'h2A4, 1'b0, 1'b0},
    {10'h295, 1'b0, 1'b0}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; asel = 1'b0; pgm_strobe = 1'b0; code_in = 1'b0;
    tick(2);
    rst_n = 1'b1;
  endtask

  task automatic send_code(input logic [9:0] c, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      code_in = c[i];
      tick(1);
    end
  endtask

  // high phase of nhigh edges, 2 hold edges, then low byte for 13 edges
  task automatic load_addr(input logic [2:0] hi, input logic [7:0] lo, input int nhigh);
    asel = 1'b1; addr_port = {hi, 5'b0};
    tick(nhigh);
    asel = 1'b0;
    tick(2);
    addr_port = lo;
    tick(13);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      pgm_strobe = 1'b1; tick(1);
      pgm_strobe = 1'b0; tick(1);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int d0;
    tick(1);
    // reset state, before any code bit (R1, R6, R8)
    do_reset();
    check("R1 reset prog", prog_active, 0);
    check("R1 reset verify", verify_active, 0);
    check("R6 reset valid", addr_valid, 0);
    check("R8 reset oe", data_oe, 0);

    // table walk: mode decoding (R1)
    for (int v = 0; v < 5; v++) begin
      do_reset();
      send_code(VEC[v][11:2], 9);
      check("R1 nine bits prog", prog_active, 0);
      check("R1 nine bits verify", verify_active, 0);
      code_in = VEC[v][11];
      tick(1);
      check("R1 mode prog", prog_active, VEC[v][1]);
      check("R1 mode verify", verify_active, VEC[v][0]);
    end

    // program mode
    do_reset();
    send_code(10'h2A5, 10);
    send_code(10'h15A, 10);
    check("R2 mode kept", prog_active, 1);
    check("R2 verify kept low", verify_active, 0);

    load_addr(3'b101, 8'hA5, 13);
    check("R5 valid after 13", addr_valid, 0);
    tick(1);
    check("R5 valid after 14", addr_valid, 1);
    check("R8 oe low in program", data_oe, 0);
    check("R8 data_out zero", data_out, 0);

    data_in = 8'h3C;
    d0 = done_seen;
    pulses(24);
    check("R7 no write at 24", done_seen - d0, 0);
    pgm_strobe = 1'b1; tick(1);
    check("R7 done pulse", write_done, 1);
    pgm_strobe = 1'b0; tick(1);
    check("R7 done one cycle", write_done, 0);
    pulses(1);
    check("R7 one write only", done_seen - d0, 1);

    // interrupted train at 0x533
    addr_port = 8'h33; tick(14);
    data_in = 8'h77;
    d0 = done_seen;
    pulses(10);
    addr_port = 8'h34; tick(1);
    check("R5 change drops valid", addr_valid, 0);
    addr_port = 8'h33; tick(14);
    check("R5 valid again", addr_valid, 1);
    pulses(24);
    check("R7 partial count discarded", done_seen - d0, 0);
    pulses(1);
    check("R7 write after restart", done_seen - d0, 1);

    // second location, same low byte, other upper part
    load_addr(3'b000, 8'hA5, 13); tick(1);
    data_in = 8'hC3;
    asel = 1'b0;
    pulses(25);

    // short high phase then boundary
    asel = 1'b1; addr_port = 8'hE0; tick(1);
    check("R6 valid low while asel", addr_valid, 0);
    tick(11);
    asel = 1'b0; tick(2); addr_port = 8'h11; tick(20);
    check("R3 12-edge high rejected", addr_valid, 0);
    load_addr(3'b111, 8'h11, 13); tick(1);
    check("R3 13-edge high accepted", addr_valid, 1);

    // verify mode after reset
    do_reset();
    send_code(10'h15A, 10);
    load_addr(3'b101, 8'hA5, 13); tick(1);
    check("R8 oe in verify", data_oe, 1);
    check("R10 content kept 5A5", data_out, 8'h3C);
    load_addr(3'b000, 8'hA5, 13); tick(1);
    check("R3 upper bits select 0A5", data_out, 8'hC3);
    load_addr(3'b101, 8'h33, 13); tick(1);
    check("R7 restarted write 533", data_out, 8'h77);

    load_addr(3'b000, 8'hA5, 13); tick(1);
    data_in = 8'hFF;
    d0 = done_seen;
    pulses(25);
    check("R9 no write in verify", data_out, 8'hC3);
    check("R9 no done in verify", done_seen - d0, 0);
    asel = 1'b1; tick(1);
    check("R8 oe low with asel", data_oe, 0);
    check("R8 out zero with asel", data_out, 0);

    // idle code: no drive even with a valid address
    do_reset();
    send_code(10'h000, 10);
    load_addr(3'b101, 8'hA5, 13); tick(1);
    check("R6 valid in idle", addr_valid, 1);
    check("R8 oe low in idle", data_oe, 0);

    finish_run();
  end
endmodule